// File: doc/BRIEF.md
# Double-Buffered DAC Waveform Player

This block feeds a 16-bit serial DAC with one sample per conversion at a rate set in system clock cycles. Three sources can feed it. The host source is a pair of equal waveform banks. One bank plays while the host loads new data into the other. The bank in play is replayed from address zero up to a programmable length, and the host normally fills it with two signal periods. The device-under-test source is a small FIFO of its own, filled over a valid/ready stream, so it never competes with host writes. The bypass source skips all storage: the value present on a parallel input is taken as the frame starts.

At a safe point a requested bank swap exchanges the roles of the two banks, and host writes always follow the idle bank. The safe point is either the wrap at the end of the waveform or any cycle in which playback is stopped. Each sample goes out as one frame on a chip-select, clock and data link. Frames never overlap. The spacing between frames is stretched when needed so that each frame has room to finish. With the default 125 MHz clock, a divider setting of 124 gives 1 MS/s.

Top module: `dac_playback_ctrl`

## Requirements
- R1: After reset `dac_cs_n` is 1, `dac_sclk` is 0, `active_bank` is 0, `swap_pending` is 0 and `dut_ready` is 1.
- R2: A frame holds `dac_cs_n` low for exactly 32 cycles and contains 16 rising edges of `dac_sclk`. It sends the sample MSB first, with `dac_sdi` stable while `dac_sclk` is high. `dac_sclk` is 0 whenever `dac_cs_n` is high.
- R3: While running, one frame starts every `rate_div`+1 cycles. If `rate_div` is below 32, the spacing is 33 cycles.
- R4: With `src_sel`=0 (host), frames replay addresses 0 to `period_len`-1 of the active bank in order and then wrap to 0. A `period_len` of 0 acts as 1, and a value above the bank depth acts as the depth.
- R5: A host write (`hw_valid`=1; `hw_ready` is always 1) stores `hw_data` at `hw_addr` in the bank that is not active. It has no effect on the samples being played.
- R6: `swap_req` sets `swap_pending`. While running, `active_bank` toggles only when the frame that reads address `period_len`-1 starts, and `swap_pending` clears in the same cycle.
- R7: While `run` is 0, a pending swap is applied within two cycles of the request, and the next run starts from address 0.
- R8: With `src_sel`=1 (device under test), frames take FIFO entries in arrival order. An empty FIFO repeats the last sample taken, or 0 if no sample has been taken since reset. `dut_ready` is 0 while `DUT_DEPTH` entries are held, and a word offered then is dropped.
- R9: With `src_sel`=2 (bypass), each frame carries the value of `byp_data` in the cycle the frame starts.
- R10: With `src_sel`=3 or `run`=0, no frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Enables conversions |
| src_sel | input | 2 | 0 host banks, 1 device FIFO, 2 bypass, 3 silent |
| rate_div | input | 16 | Conversion spacing minus one, in cycles |
| period_len | input | 7 | Number of host samples in the loop |
| swap_req | input | 1 | One-cycle request to exchange banks |
| hw_valid | input | 1 | Host write strobe |
| hw_ready | output | 1 | Host write accept, always 1 |
| hw_addr | input | 6 | Host write address within the idle bank |
| hw_data | input | 16 | Host write sample |
| dut_valid | input | 1 | Device sample valid |
| dut_ready | output | 1 | Device FIFO has room |
| dut_data | input | 16 | Device sample |
| byp_data | input | 16 | Bypass sample |
| active_bank | output | 1 | Bank currently played |
| swap_pending | output | 1 | A swap is waiting for its safe point |
| dac_cs_n | output | 1 | DAC chip select, active low |
| dac_sclk | output | 1 | DAC serial clock |
| dac_sdi | output | 1 | DAC serial data |

## Verification
The assertions check the link timing on every cycle. They confirm that the clock stays inside chip select, that data holds while the clock is high and that each chip-select pulse lasts 32 cycles. They also check that the bank changes only when a swap is pending and that the pending flag clears only together with a bank change. Sample values and source behaviour can only be shown by the bench scenarios. These cover the replay order and wrap point, the frame in which a swap lands, the isolation of writes to the idle bank, FIFO order with hold-last and drop-when-full, bypass capture timing, frame spacing with and without the clamp, and silence.

// File: rtl/dac_pb_pkg.sv
package dac_pb_pkg;
  typedef enum logic [1:0] {
    SRC_HOST = 2'd0,
    SRC_DUT  = 2'd1,
    SRC_BYP  = 2'd2,
    SRC_NONE = 2'd3
  } src_e;

  // cycles chip select stays low for one sample
  function automatic int frame_cycles(input int data_w);
    return 2 * data_w;
  endfunction
endpackage

// File: rtl/dac_pb_pacer.sv
module dac_pb_pacer #(
  parameter int DIV_W   = 16,
  parameter int MIN_DIV = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] rate_div,
  input  logic             busy,
  output logic             start
);
  localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_DIV);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] eff;

  assign eff   = (rate_div < MIN_V) ? MIN_V : rate_div;
  assign start = run && !busy && (cnt >= eff);

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || start) cnt <= '0;
    else if (cnt < eff)     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dac_pb_seq.sv
module dac_pb_seq #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              adv,
  input  logic              swap_req,
  input  logic [ADDR_W:0]   period_len,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              active_bank,
  output logic              swap_pending
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W:0] DEPTH_V = (ADDR_W+1)'(DEPTH);

  logic [ADDR_W:0] len_c;
  logic [ADDR_W:0] last_ix;
  logic            at_end;

  assign len_c   = (period_len > DEPTH_V) ? DEPTH_V : period_len;
  assign last_ix = (len_c == '0) ? '0 : len_c - 1'b1;
  assign at_end  = ({1'b0, rd_addr} >= last_ix);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_addr      <= '0;
      active_bank  <= 1'b0;
      swap_pending <= 1'b0;
    end else begin
      if (!run) begin
        rd_addr <= '0;
        if (swap_pending) begin
          active_bank  <= ~active_bank;
          swap_pending <= 1'b0;
        end
      end else if (adv) begin
        if (at_end) begin
          rd_addr <= '0;
          if (swap_pending) begin
            active_bank  <= ~active_bank;
            swap_pending <= 1'b0;
          end
        end else begin
          rd_addr <= rd_addr + 1'b1;
        end
      end
      if (swap_req) swap_pending <= 1'b1;
    end
  end
endmodule

// File: rtl/dac_pb_banks.sv
module dac_pb_banks #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              active_bank,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] bank_q [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && (active_bank != 1'(b))) mem[wr_addr] <= wr_data;
    end
    assign bank_q[b] = mem[rd_addr];
  end

  assign rd_data = bank_q[active_bank];
endmodule

// File: rtl/dac_pb_fifo.sv
module dac_pb_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              pop,
  output logic [DATA_W-1:0] out_data,
  output logic              empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_V = CW'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wp, rp;
  logic [CW-1:0]     cnt;
  logic              push, take;

  assign in_ready = (cnt != FULL_V);
  assign empty    = (cnt == '0);
  assign push     = in_valid && in_ready;
  assign take     = pop && !empty;
  assign out_data = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (take) rp <= rp + 1'b1;
      case ({push, take})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/dac_pb_ser.sv
module dac_pb_ser #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  output logic              busy,
  output logic              cs_n,
  output logic              sclk,
  output logic              sdi
);
  localparam int BW = $clog2(DATA_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  logic [DATA_W-1:0] sh;
  logic [BW-1:0]     bitn;
  logic              ph;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_n <= 1'b1;
      sclk <= 1'b0;
      sh   <= '0;
      bitn <= '0;
      ph   <= 1'b0;
    end else if (cs_n) begin
      if (start) begin
        sh   <= data;
        cs_n <= 1'b0;
        sclk <= 1'b0;
        bitn <= '0;
        ph   <= 1'b0;
      end
    end else if (!ph) begin
      sclk <= 1'b1;
      ph   <= 1'b1;
    end else begin
      sclk <= 1'b0;
      ph   <= 1'b0;
      if (bitn == LAST_BIT) begin
        cs_n <= 1'b1;
      end else begin
        bitn <= bitn + 1'b1;
        sh   <= {sh[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign sdi  = sh[DATA_W-1];
  assign busy = !cs_n;
endmodule

// File: rtl/dac_playback_ctrl.sv
module dac_playback_ctrl
  import dac_pb_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 6,
  parameter int DUT_DEPTH = 8,
  parameter int DIV_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [1:0]        src_sel,
  input  logic [DIV_W-1:0]  rate_div,
  input  logic [ADDR_W:0]   period_len,
  input  logic              swap_req,
  input  logic              hw_valid,
  output logic              hw_ready,
  input  logic [ADDR_W-1:0] hw_addr,
  input  logic [DATA_W-1:0] hw_data,
  input  logic              dut_valid,
  output logic              dut_ready,
  input  logic [DATA_W-1:0] dut_data,
  input  logic [DATA_W-1:0] byp_data,
  output logic              active_bank,
  output logic              swap_pending,
  output logic              dac_cs_n,
  output logic              dac_sclk,
  output logic              dac_sdi
);
  localparam int MIN_DIV = frame_cycles(DATA_W);

  src_e              src;
  logic              run_eff, start, ser_busy;
  logic              adv, pop;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] bank_rd, fifo_out, last_dut, sample;
  logic              fifo_empty;

  assign src      = src_e'(src_sel);
  assign run_eff  = run && (src != SRC_NONE);
  assign hw_ready = 1'b1;
  assign adv      = start && (src == SRC_HOST);
  assign pop      = start && (src == SRC_DUT) && !fifo_empty;

  dac_pb_pacer #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_pacer (
    .clk(clk), .rst_n(rst_n), .run(run_eff), .rate_div(rate_div),
    .busy(ser_busy), .start(start)
  );

  dac_pb_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .adv(adv), .swap_req(swap_req),
    .period_len(period_len), .rd_addr(rd_addr),
    .active_bank(active_bank), .swap_pending(swap_pending)
  );

  dac_pb_banks #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_banks (
    .clk(clk), .active_bank(active_bank), .wr_en(hw_valid),
    .wr_addr(hw_addr), .wr_data(hw_data), .rd_addr(rd_addr), .rd_data(bank_rd)
  );

  dac_pb_fifo #(.DATA_W(DATA_W), .DEPTH(DUT_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .in_valid(dut_valid), .in_ready(dut_ready),
    .in_data(dut_data), .pop(pop), .out_data(fifo_out), .empty(fifo_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)   last_dut <= '0;
    else if (pop) last_dut <= fifo_out;
  end

  always_comb begin
    case (src)
      SRC_HOST: sample = bank_rd;
      SRC_DUT:  sample = fifo_empty ? last_dut : fifo_out;
      SRC_BYP:  sample = byp_data;
      default:  sample = '0;
    endcase
  end

  dac_pb_ser #(.DATA_W(DATA_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .start(start), .data(sample), .busy(ser_busy),
    .cs_n(dac_cs_n), .sclk(dac_sclk), .sdi(dac_sdi)
  );
endmodule

// File: rtl/dac_pb_chk.sv
module dac_pb_chk #(
  parameter int DATA_W = 16
) (
  input logic clk,
  input logic rst_n,
  input logic dac_cs_n,
  input logic dac_sclk,
  input logic dac_sdi,
  input logic active_bank,
  input logic swap_pending
);
  localparam int FRAME = 2 * DATA_W;
  localparam int LW = $clog2(FRAME + 2);

  logic [LW-1:0] lowcnt;

  always_ff @(posedge clk) begin
    if (!rst_n)        lowcnt <= '0;
    else if (!dac_cs_n) lowcnt <= lowcnt + 1'b1;
    else               lowcnt <= '0;
  end

  // R2
  sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_sclk |-> !dac_cs_n);

  // R2
  sdi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_sclk |-> $stable(dac_sdi));

  // R2
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_cs_n) |-> (lowcnt == LW'(FRAME)));

  // R6
  bank_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_bank != $past(active_bank)) |-> $past(swap_pending));

  // R6
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(swap_pending) |-> (active_bank != $past(active_bank)));
endmodule

bind dac_playback_ctrl dac_pb_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dac_cs_n(dac_cs_n), .dac_sclk(dac_sclk),
  .dac_sdi(dac_sdi), .active_bank(active_bank), .swap_pending(swap_pending)
);

// File: tb/dac_playback_ctrl_test.sv
`timescale 1ns/1ps
module dac_playback_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [1:0]  src_sel = 2'd0;
  logic [15:0] rate_div = 16'd40;
  logic [6:0]  period_len = 7'd4;
  logic        swap_req = 1'b0;
  logic        hw_valid = 1'b0;
  logic        hw_ready;
  logic [5:0]  hw_addr = '0;
  logic [15:0] hw_data = '0;
  logic        dut_valid = 1'b0;
  logic        dut_ready;
  logic [15:0] dut_data = '0;
  logic [15:0] byp_data = '0;
  logic        active_bank, swap_pending, dac_cs_n, dac_sclk, dac_sdi;

  int total = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dac_playback_ctrl uut (
    .clk(clk), .rst_n(rst_n), .run(run), .src_sel(src_sel), .rate_div(rate_div),
    .period_len(period_len), .swap_req(swap_req), .hw_valid(hw_valid),
    .hw_ready(hw_ready), .hw_addr(hw_addr), .hw_data(hw_data),
    .dut_valid(dut_valid), .dut_ready(dut_ready), .dut_data(dut_data),
    .byp_data(byp_data), .active_bank(active_bank), .swap_pending(swap_pending),
    .dac_cs_n(dac_cs_n), .dac_sclk(dac_sclk), .dac_sdi(dac_sdi)
  );

  // frame monitor
  logic [15:0] words [0:511];
  int          fall_t [0:511];
  int          nfr = 0, nfall = 0, bad_edges = 0, edges = 0;
  logic [15:0] shin = '0;
  logic        p_cs = 1'b1, p_sclk = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!dac_cs_n && p_cs) begin
        fall_t[nfall] = cyc;
        nfall = nfall + 1;
        edges = 0;
      end
      if (!dac_cs_n && dac_sclk && !p_sclk) begin
        shin = {shin[14:0], dac_sdi};
        edges = edges + 1;
      end
      if (dac_cs_n && !p_cs) begin
        words[nfr] = shin;
        nfr = nfr + 1;
        if (edges != 16) bad_edges = bad_edges + 1;
      end
    end
    p_cs = dac_cs_n;
    p_sclk = dac_sclk;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp, input string what);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] host1(input int k);
    return 16'h8001 + 16'(16'h1111 * (k % 4));
  endfunction
  function automatic logic [15:0] host0(input int k);
    return 16'h3C05 + 16'(16'h0101 * (k % 4));
  endfunction

  task automatic wait_frames(input int target);
    while (nfr < target) @(negedge clk);
  endtask

  task automatic write_host(input int n, input bit which);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hw_valid = 1'b1;
      hw_addr  = 6'(i);
      hw_data  = which ? host1(i) : host0(i);
    end
    @(negedge clk);
    hw_valid = 1'b0;
  endtask

  task automatic pulse_swap();
    @(negedge clk);
    swap_req = 1'b1;
    @(negedge clk);
    swap_req = 1'b0;
  endtask

  task automatic stop_run();
    @(negedge clk);
    run = 1'b0;
    wait_cs_high();
  endtask

  task automatic wait_cs_high();
    while (!dac_cs_n) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dac_cs_n == 1'b1, "R1", 32'(dac_cs_n), 1, "cs_n after reset");
    chk(dac_sclk == 1'b0, "R1", 32'(dac_sclk), 0, "sclk after reset");
    chk(active_bank == 1'b0, "R1", 32'(active_bank), 0, "bank after reset");
    chk(swap_pending == 1'b0, "R1", 32'(swap_pending), 0, "pending after reset");
    chk(dut_ready == 1'b1, "R1", 32'(dut_ready), 1, "dut_ready after reset");
  endtask

  task automatic t_host_play();
    int base, fb;
    write_host(4, 1'b1);
    pulse_swap();
    @(negedge clk);
    // R7 swap applied while stopped
    chk(active_bank == 1'b1, "R7", 32'(active_bank), 1, "stopped swap bank");
    chk(swap_pending == 1'b0, "R7", 32'(swap_pending), 0, "stopped swap pending");
    src_sel = 2'd0; period_len = 7'd4; rate_div = 16'd40;
    base = nfr; fb = nfall;
    run = 1'b1;
    wait_frames(base + 6);
    for (int k = 0; k < 6; k++)
      chk(words[base+k] == host1(k), "R4", 32'(words[base+k]), 32'(host1(k)), "host replay");
    for (int k = 0; k < 5; k++)
      chk(fall_t[fb+k+1] - fall_t[fb+k] == 41, "R3", 32'(fall_t[fb+k+1] - fall_t[fb+k]), 41,
          "frame spacing");
  endtask

  task automatic t_write_swap(input int base);
    int n, m, f, n0;
    write_host(4, 1'b0);
    n0 = nfr;
    wait_frames(n0 + 4);
    for (int k = n0 - base; k < n0 - base + 4; k++)
      chk(words[base+k] == host1(k), "R5", 32'(words[base+k]), 32'(host1(k)),
          "idle-bank write left playback intact");
    n0 = nfr;
    wait_frames(n0 + 1);
    n = nfr - base;
    @(negedge clk);
    swap_req = 1'b1;
    @(negedge clk);
    swap_req = 1'b0;
    chk(swap_pending == 1'b1, "R6", 32'(swap_pending), 1, "pending after request");
    chk(active_bank == 1'b1, "R6", 32'(active_bank), 1, "no early flip");
    m = n;
    while (m % 4 != 3) m++;
    f = m + 1;
    wait_frames(base + f + 4);
    for (int k = n; k < f + 4; k++) begin
      if (k < f)
        chk(words[base+k] == host1(k), "R6", 32'(words[base+k]), 32'(host1(k)), "before wrap");
      else
        chk(words[base+k] == host0(k), "R6", 32'(words[base+k]), 32'(host0(k)), "after wrap");
    end
    chk(active_bank == 1'b0, "R6", 32'(active_bank), 0, "bank after wrap swap");
    chk(swap_pending == 1'b0, "R6", 32'(swap_pending), 0, "pending cleared");
    // R7 restart from address 0
    stop_run();
    n0 = nfr;
    run = 1'b1;
    wait_frames(n0 + 1);
    chk(words[n0] == host0(0), "R7", 32'(words[n0]), 32'(host0(0)), "restart at addr 0");
    stop_run();
  endtask

  task automatic t_dut();
    int n0;
    src_sel = 2'd1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      dut_valid = 1'b1;
      dut_data  = 16'h5A00 + 16'(i);
    end
    @(negedge clk);
    dut_data = 16'hDEAD;
    chk(dut_ready == 1'b0, "R8", 32'(dut_ready), 0, "ready low when full");
    @(negedge clk);
    dut_valid = 1'b0;
    n0 = nfr;
    run = 1'b1;
    wait_frames(n0 + 10);
    for (int k = 0; k < 10; k++) begin
      logic [15:0] e;
      e = (k < 8) ? 16'h5A00 + 16'(k) : 16'h5A07;
      chk(words[n0+k] == e, "R8", 32'(words[n0+k]), 32'(e), "fifo order / hold last");
    end
    stop_run();
  endtask

  task automatic t_bypass();
    int n0;
    src_sel = 2'd2;
    byp_data = 16'h1234;
    n0 = nfr;
    run = 1'b1;
    wait_frames(n0 + 2);
    chk(words[n0] == 16'h1234, "R9", 32'(words[n0]), 32'h1234, "bypass first");
    chk(words[n0+1] == 16'h1234, "R9", 32'(words[n0+1]), 32'h1234, "bypass second");
    @(negedge clk);
    byp_data = 16'hFEDC;
    wait_frames(n0 + 3);
    chk(words[n0+2] == 16'hFEDC, "R9", 32'(words[n0+2]), 32'hFEDC, "bypass new value");
    stop_run();
  endtask

  task automatic t_clamp();
    int fb;
    rate_div = 16'd5;
    fb = nfall;
    run = 1'b1;
    wait_frames(nfr + 4);
    for (int k = 0; k < 3; k++)
      chk(fall_t[fb+k+1] - fall_t[fb+k] == 33, "R3", 32'(fall_t[fb+k+1] - fall_t[fb+k]), 33,
          "clamped spacing");
    stop_run();
    rate_div = 16'd124;
    fb = nfall;
    run = 1'b1;
    wait_frames(nfr + 3);
    chk(fall_t[fb+1] - fall_t[fb] == 125, "R3", 32'(fall_t[fb+1] - fall_t[fb]), 125,
        "1 MS/s spacing");
    stop_run();
  endtask

  task automatic t_silent();
    int f0;
    rate_div = 16'd40;
    src_sel = 2'd3;
    f0 = nfall;
    run = 1'b1;
    repeat (200) @(negedge clk);
    chk(nfall == f0, "R10", 32'(nfall - f0), 0, "frames with source 3");
    run = 1'b0;
    src_sel = 2'd2;
    repeat (200) @(negedge clk);
    chk(nfall == f0, "R10", 32'(nfall - f0), 0, "frames with run low");
    chk(bad_edges == 0, "R2", 32'(bad_edges), 0, "frames without 16 clock edges");
  endtask

  initial begin
    int base;
    t_reset();
    base = nfr;
    t_host_play();
    t_write_swap(base);
    t_dut();
    t_bypass();
    t_clamp();
    t_silent();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(8 * 150000);
    total++;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule